// File: doc/BRIEF.md
# Two-Bank Shared-Row Nibble Read Sequencer

This block runs read cycles for two DRAM banks whose data pins are wired together. One row strobe opens the same row in both banks at once. The first bank then delivers a four-beat nibble burst. The second bank follows after only the column access delay, and only one bank at a time has its column strobe active on the shared data lines.

When the system holds a single bank, a configuration input selects a fallback path. After the first burst the row strobe is released for the full precharge time, and the row is strobed again. A second four-beat burst is then read from the same bank. Every timing value is given in clock cycles. The nibble beat period defaults to 25 cycles, which is 125 ns at a 5 ns clock.

A request carries one word address. The upper bits form the row and the lower bits form the column. The DRAM steps through the column inside a burst on its own. The controller reports each beat with a data-valid strobe and ends each request with a done pulse.

Top module: `qi_nibble_ctrl`

## Requirements
- R1: While reset is held, ras_n is 1, cas_n is 2'b11, and data_valid, done and req_ready are all 0.
- R2: req_ready is 1 only when the controller is idle and ras_n has been high for at least T_RP consecutive cycles. After a done pulse in cycle D, req_ready first rises in cycle D+T_RP. A request is taken at a clock edge where req_valid and req_ready are both 1, and that edge also samples req_addr and bank_present.
- R3: In the cycle after the request is taken, ras_n falls and stays low for T_RCD cycles before any column strobe. During those cycles no cas_n bit is low, and dram_addr carries the row, which is req_addr[ADDR_W-1:COL_W].
- R4: In every beat cycle, dram_addr carries the column of the request, which is req_addr[COL_W-1:0], zero-extended.
- R5: At most one bit of cas_n is low in any cycle. Bit 0 strobes bank 0 and bit 1 strobes bank 1. The first burst of every request comes from bank 0.
- R6: The first data_valid comes T_RCD+T_CAC cycles after the request edge. It is followed by three more at intervals of T_NIB cycles.
- R7: With bank_present = 1, the first bank-1 beat comes T_NIB+T_CAC cycles after the fourth bank-0 beat. ras_n stays low between the two bursts, so there is exactly one row strobe per request.
- R8: With bank_present = 0, ras_n rises T_NIB cycles after the fourth beat and stays high for T_RP cycles. It then falls again with the row on dram_addr. After a further T_RCD+T_CAC cycles, four more bank-0 beats follow, each T_NIB cycles apart.
- R9: Each request yields exactly eight data_valid pulses. done is a one-cycle pulse T_NIB cycles after the eighth pulse, and ras_n is high in that cycle.
- R10: While a request is in progress, req_valid, req_addr and bank_present have no effect on any output.
- R11: Within each beat, the active cas_n bit is high in the beat's last cycle. data_valid is 1 only in the first cycle of a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address, row in upper bits, column in lower bits |
| bank_present | input | 1 | 1 when the second bank is fitted |
| req_ready | output | 1 | Request can be taken this cycle |
| ras_n | output | 1 | Row strobe shared by both banks, active low |
| cas_n | output | 2 | Per-bank column strobe, active low |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| data_valid | output | 1 | One pulse per data beat |
| done | output | 1 | End-of-request pulse |

## Verification
Requests are issued with bank_present high and low, so the short bank-switch gap can be told apart from the precharge and re-strobe path by beat timing, by the strobed bank and by the number of row strobes. Complementary row and column patterns (all ones against all zeros, 0xA5 against 0x5A) show whether the address multiplexer ever puts the wrong field on the pins. Two requests hold req_valid high and flip bank_present while busy, which exposes any input leaking into a request in progress. The ready timing after each done pulse separates a correct precharge gate from one that is too short or too long.

// File: rtl/qi_nibble_pkg.sv
`timescale 1ns/1ps
package qi_nibble_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_ACC,
    ST_BEAT,
    ST_PRE,
    ST_DONE
  } qi_state_e;

  // Row strobe is held low from row open until the last beat of a row cycle.
  function automatic logic fn_ras_on(qi_state_e s);
    return (s == ST_RCD) || (s == ST_ACC) || (s == ST_BEAT);
  endfunction

  // Column address is driven once the column strobe may be active.
  function automatic logic fn_col_phase(qi_state_e s);
    return (s == ST_ACC) || (s == ST_BEAT);
  endfunction

  function automatic int fn_max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/qi_phase_timer.sv
`timescale 1ns/1ps
module qi_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/qi_addr_mux.sv
`timescale 1ns/1ps
module qi_addr_mux #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int OUT_W = 8
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             sel_col,
  output logic [OUT_W-1:0] addr_out
);

  assign addr_out = sel_col ? OUT_W'(col) : OUT_W'(row);

endmodule

// File: rtl/qi_nibble_ctrl.sv
`timescale 1ns/1ps
module qi_nibble_ctrl
  import qi_nibble_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int T_RP  = 16,  // row precharge, cycles (>= 1)
  parameter int T_RCD = 4,   // row to column strobe, cycles (>= 1)
  parameter int T_CAC = 3,   // column access, cycles (>= 1)
  parameter int T_NIB = 25,  // nibble beat period, cycles (>= 2)
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bank_present,
  output logic              req_ready,
  output logic              ras_n,
  output logic [1:0]        cas_n,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              data_valid,
  output logic              done
);

  localparam int T_MAX = fn_max4(T_RP, T_RCD, T_CAC, T_NIB);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int RP_W  = $clog2(T_RP + 1);
  localparam int NBANK = 2;

  qi_state_e        state, nxt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             dual_q, bank_q, pass_q;
  logic [1:0]       beat_q;
  logic [RP_W-1:0]  rp_cnt;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val, t_cnt;

  // Named internal events
  logic accept, beat_end, burst_end, bank_switch, restrobe, cas_on, ras_on;

  assign accept      = req_valid && req_ready;
  assign beat_end    = (state == ST_BEAT) && t_zero;
  assign burst_end   = beat_end && (beat_q == 2'd3);
  assign bank_switch = burst_end && !pass_q && dual_q;
  assign restrobe    = burst_end && !pass_q && !dual_q;
  assign ras_on      = fn_ras_on(state);
  assign cas_on      = (state == ST_ACC) || ((state == ST_BEAT) && !t_zero);

  qi_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .cnt(t_cnt), .zero(t_zero)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        nxt = ST_RCD; t_load = 1'b1; t_val = CNT_W'(T_RCD - 1);
      end
      ST_RCD: if (t_zero) begin
        nxt = ST_ACC; t_load = 1'b1; t_val = CNT_W'(T_CAC - 1);
      end
      ST_ACC: if (t_zero) begin
        nxt = ST_BEAT; t_load = 1'b1; t_val = CNT_W'(T_NIB - 1);
      end
      ST_BEAT: if (t_zero) begin
        if (beat_q != 2'd3) begin
          t_load = 1'b1; t_val = CNT_W'(T_NIB - 1);
        end else if (!pass_q) begin
          t_load = 1'b1;
          if (dual_q) begin nxt = ST_ACC; t_val = CNT_W'(T_CAC - 1); end
          else        begin nxt = ST_PRE; t_val = CNT_W'(T_RP - 1);  end
        end else begin
          nxt = ST_DONE;
        end
      end
      ST_PRE: if (t_zero) begin
        nxt = ST_RCD; t_load = 1'b1; t_val = CNT_W'(T_RCD - 1);
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      dual_q <= 1'b0;
      bank_q <= 1'b0;
      pass_q <= 1'b0;
      beat_q <= 2'd0;
      rp_cnt <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        row_q  <= req_addr[ADDR_W-1:COL_W];
        col_q  <= req_addr[COL_W-1:0];
        dual_q <= bank_present;
        bank_q <= 1'b0;
        pass_q <= 1'b0;
      end
      if ((state == ST_ACC) && t_zero)          beat_q <= 2'd0;
      else if (beat_end && beat_q != 2'd3)      beat_q <= beat_q + 2'd1;
      if (burst_end && !pass_q) begin
        pass_q <= 1'b1;
        bank_q <= dual_q;
      end
      if (ras_on)                               rp_cnt <= '0;
      else if (rp_cnt != RP_W'(T_RP))           rp_cnt <= rp_cnt + 1'b1;
    end
  end

  qi_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .OUT_W(MUX_W)) mux_i (
    .row(row_q), .col(col_q), .sel_col(fn_col_phase(state)), .addr_out(dram_addr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_cas
    assign cas_n[b] = !(cas_on && (int'(bank_q) == b));
  end

  assign ras_n      = !ras_on;
  assign data_valid = (state == ST_BEAT) && (t_cnt == CNT_W'(T_NIB - 1));
  assign done       = (state == ST_DONE);
  assign req_ready  = (state == ST_IDLE) && (rp_cnt == RP_W'(T_RP));

  // R5
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cas_n) <= 1);
  // R3
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 2'b11) |-> !ras_n);
  // R2
  accept_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!ras_n && cas_n == 2'b11));
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !req_ready);
  // R7
  bank_switch_keeps_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_switch |=> (!ras_n && cas_n == 2'b01));
  // R8
  restrobe_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restrobe |=> (ras_n && cas_n == 2'b11));
  // R9
  done_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ras_n && !data_valid && cas_n == 2'b11));
  // R11
  beat_has_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (cas_n != 2'b11));

endmodule

// File: tb/qi_nibble_ctrl_tb_top.sv
`timescale 1ns/1ps
module qi_nibble_ctrl_tb_top;

  localparam int ROW_W = 8;
  localparam int COL_W = 8;
  localparam int T_RP  = 16;
  localparam int T_RCD = 4;
  localparam int T_CAC = 3;
  localparam int T_NIB = 25;

  typedef struct {
    int    cyc;
    int    bank;
    int    addr;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        bank_present = 1'b0;
  logic        req_ready, ras_n, data_valid, done;
  logic [1:0]  cas_n;
  logic [7:0]  dram_addr;

  always #2.5 clk = ~clk;

  qi_nibble_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_NIB(T_NIB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .bank_present(bank_present), .req_ready(req_ready), .ras_n(ras_n),
    .cas_n(cas_n), .dram_addr(dram_addr), .data_valid(data_valid), .done(done)
  );

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  exp_t beat_q[$];
  exp_t ras_q[$];
  int   done_q[$];
  int   cas_hi_at = -1;
  logic prev_ras = 1'b1;
  bit   finished = 0;
  int   prev_done = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (data_valid) begin
        if (beat_q.size() == 0) chk(0, "R9", cyc, -1, "unexpected data_valid");
        else begin
          exp_t e;
          int   b;
          e = beat_q.pop_front();
          chk(cyc == e.cyc, e.tag, cyc, e.cyc, "beat cycle");
          b = (cas_n == 2'b10) ? 0 : (cas_n == 2'b01) ? 1 : -1;
          chk(b == e.bank, "R5", b, e.bank, "strobed bank");
          chk(int'(dram_addr) == e.addr, "R4", int'(dram_addr), e.addr, "column address");
          cas_hi_at = cyc + T_NIB - 1;
        end
      end
      if (cyc == cas_hi_at) chk(cas_n == 2'b11, "R11", int'(cas_n), 3, "cas high at beat end");
      if (!ras_n && prev_ras) begin
        if (ras_q.size() == 0) chk(0, "R7", cyc, -1, "unexpected row strobe");
        else begin
          exp_t r;
          r = ras_q.pop_front();
          chk(cyc == r.cyc, r.tag, cyc, r.cyc, "row strobe cycle");
          chk(int'(dram_addr) == r.addr, "R3", int'(dram_addr), r.addr, "row address");
        end
      end
      prev_ras = ras_n;
      if (done) begin
        if (done_q.size() == 0) chk(0, "R9", cyc, -1, "unexpected done");
        else begin
          int d;
          d = done_q.pop_front();
          chk(cyc == d, "R9", cyc, d, "done cycle");
          chk(ras_n == 1'b1, "R9", int'(ras_n), 1, "ras high at done");
        end
      end
    end
  end

  // Driver: issues one request and pushes everything it must produce
  task automatic run_req(int row, int col, bit bp, bit junk);
    int a, f, f2, d;
    bit two;
    two = bp;
    while (!req_ready) @(negedge clk);
    if (prev_done >= 0) chk(cyc == prev_done + T_RP, "R2", cyc, prev_done + T_RP, "first ready cycle");
    req_valid    = 1'b1;
    req_addr     = 16'((row << COL_W) | col);
    bank_present = bp;
    @(posedge clk);
    @(negedge clk);
    a = cyc;
    // R10: inputs disturbed while busy
    req_valid    = junk;
    bank_present = junk ? ~bp : bp;
    req_addr     = junk ? ~req_addr : req_addr;
    f = a + T_RCD + T_CAC;
    ras_q.push_back('{a, 0, row, "R3"});
    for (int i = 0; i < 4; i++) beat_q.push_back('{f + i*T_NIB, 0, col, "R6"});
    if (two) begin
      f2 = f + 4*T_NIB + T_CAC;
      for (int i = 0; i < 4; i++) beat_q.push_back('{f2 + i*T_NIB, 1, col, "R7"});
    end else begin
      ras_q.push_back('{f + 4*T_NIB + T_RP, 0, row, "R8"});
      f2 = f + 4*T_NIB + T_RP + T_RCD + T_CAC;
      for (int i = 0; i < 4; i++) beat_q.push_back('{f2 + i*T_NIB, 0, col, "R8"});
    end
    d = f2 + 4*T_NIB;
    done_q.push_back(d);
    while (cyc < f2) @(negedge clk);
    req_valid = 1'b0;
    while (cyc <= d) @(negedge clk);
    chk(beat_q.size() == 0, "R9", beat_q.size(), 0, "beats left after done");
    prev_done = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1, "R1", int'(ras_n), 1, "ras_n in reset");
    chk(cas_n == 2'b11, "R1", int'(cas_n), 3, "cas_n in reset");
    chk(!data_valid && !done, "R1", int'({data_valid, done}), 0, "valid/done in reset");
    chk(!req_ready, "R1", int'(req_ready), 0, "ready in reset");
    rst_n = 1'b1;
    run_req(8'hFF, 8'h00, 1'b1, 1'b0);
    run_req(8'h00, 8'hFF, 1'b0, 1'b0);
    run_req(8'hA5, 8'h5A, 1'b1, 1'b1);
    run_req(8'h5A, 8'hA5, 1'b0, 1'b1);
    run_req(8'h3C, 8'h81, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk(beat_q.size() == 0 && ras_q.size() == 0 && done_q.size() == 0, "R9",
        beat_q.size() + ras_q.size() + done_q.size(), 0, "items left");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule